// File: doc/BRIEF.md
# 8-to-16-bit ATA Data Bridge

This block lets a host whose I/O bus is only one byte wide talk to a drive whose data register is sixteen bits wide. It claims a 16-byte window of host I/O space. The window starts at one of two base addresses, and a configuration input picks which one. Inside the window, host address bits 3..1 name one of eight drive registers. Host address bit 0 names the byte half of a sixteen-bit transfer.

Drive register 0 carries sector data. The host moves one word as two host cycles: the even address first, then the odd address. A one-byte holding register carries the second byte across. On a read, the even cycle fetches the whole word from the drive and parks its upper byte. On a write, the even cycle parks the lower byte and the odd cycle performs the drive write. Drive registers 1 to 7 are command registers, and each access to one of them is a single byte.

The host strobes are registered on a system clock. After the drive write strobe is released, the drive data outputs stay enabled for a set number of clock cycles, so the drive sees valid data past its hold requirement.

Top module: `ata8_bridge`

## Requirements
- R1: Accesses outside the selected window create no drive strobe and leave `host_doe` low. `base_sel`=0 selects base 0x300 and `base_sel`=1 selects base 0x320.
- R2: Inside the window, the drive register address equals host address bits 3..1, so drive register n sits at host offset 2n.
- R3: A read of drive register 0 at an even offset asserts `drv_rd_n` low. It returns `drv_din[7:0]` to the host and stores `drv_din[15:8]` in the holding register.
- R4: A read of drive register 0 at an odd offset keeps `drv_rd_n` high and returns the holding register, which is the byte stored by the most recent holding-register load.
- R5: A write of drive register 0 at an even offset keeps `drv_wr_n` high and stores the host byte in the holding register.
- R6: A write of drive register 0 at an odd offset asserts `drv_wr_n` low with `drv_dout` = {host byte, holding register}, so the pair of byte writes stores one word.
- R7: An access to drive registers 1 to 7 passes the strobe to the drive for either value of address bit 0. Reads return `drv_din[7:0]`. Writes drive `drv_dout[15:8]`=0 and the host byte on `drv_dout[7:0]`. Odd offsets never load the holding register.
- R8: After `drv_wr_n` rises, `drv_doe` stays high for exactly HOLD_CYC more clock cycles, and `drv_dout` stays stable during that time.
- R9: While reset is held, `drv_rd_n` and `drv_wr_n` are high and `drv_doe` and `host_doe` are low.
- R10: `host_doe` is high only while a read strobe is decoded inside the window. It is low during writes and when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Window base: 0 selects 0x300, 1 selects 0x320 |
| host_addr | input | 10 | Host I/O address |
| host_ior_n | input | 1 | Host read strobe, active low |
| host_iow_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Byte written by the host |
| host_dout | output | 8 | Byte returned to the host |
| host_doe | output | 1 | Enable for driving the host data bus |
| drv_addr | output | 3 | Drive register address |
| drv_rd_n | output | 1 | Drive read strobe, active low |
| drv_wr_n | output | 1 | Drive write strobe, active low |
| drv_din | input | 16 | Word presented by the drive |
| drv_dout | output | 16 | Word presented to the drive |
| drv_doe | output | 1 | Enable for driving the drive data lines, including the hold extension |

## Verification
The main stimulus is a series of word transfers done as paired byte cycles, checked against a behavioural model of the drive's register file. Running the normal even-then-odd order shows whether both bytes land in the right halves. Reading the odd byte before its even partner shows that the holding register, and not the drive, serves the odd cycle. Byte accesses to registers 1 to 7 at even and odd offsets separate command traffic from data traffic. The bench counts drive strobe pulses to show which cycles are suppressed, and it switches between the two window bases to show that out-of-window accesses do nothing.

// File: rtl/ata8_pkg.sv
package ata8_pkg;
   // classification of one decoded host access
   typedef enum logic [1:0] {
      ACC_NONE    = 2'd0,
      ACC_CMD     = 2'd1,
      ACC_DATA_LO = 2'd2,
      ACC_DATA_HI = 2'd3
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic hit, input logic is_data, input logic odd);
      if (!hit)
         return ACC_NONE;
      else if (!is_data)
         return ACC_CMD;
      else if (odd)
         return ACC_DATA_HI;
      else
         return ACC_DATA_LO;
   endfunction
endpackage

// File: rtl/ata8_window_decode.sv
module ata8_window_decode
   import ata8_pkg::*;
#(
   parameter int          ADDR_W  = 10,
   parameter int          WIN_W   = 4,
   parameter logic [9:0]  BASE_LO = 10'h300,
   parameter logic [9:0]  BASE_HI = 10'h320,
   localparam int         REG_W   = WIN_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              base_sel,
   output logic              hit,
   output logic [REG_W-1:0]  reg_idx,
   output logic              odd,
   output acc_kind_e         kind
);
   localparam int TAG_W = ADDR_W - WIN_W;

   initial begin
      if (WIN_W < 2 || WIN_W >= ADDR_W)
         $error("window width out of range");
      if (BASE_LO[WIN_W-1:0] != '0 || BASE_HI[WIN_W-1:0] != '0)
         $error("window bases must be aligned to the window size");
   end

   logic [TAG_W-1:0] base_tag;
   logic             is_data;

   always_comb begin
      base_tag = base_sel ? BASE_HI[ADDR_W-1:WIN_W] : BASE_LO[ADDR_W-1:WIN_W];
      hit      = (addr[ADDR_W-1:WIN_W] == base_tag);
      reg_idx  = addr[WIN_W-1:1];
      odd      = addr[0];
      is_data  = (reg_idx == '0);
      kind     = classify(hit, is_data, odd);
   end
endmodule

// File: rtl/ata8_byte_hold.sv
module ata8_byte_hold #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] d,
   output logic [BYTE_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/ata8_hold_timer.sv
module ata8_hold_timer #(
   parameter int HOLD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic extend
);
   initial begin
      if (HOLD_CYC < 0)
         $error("hold count must not be negative");
   end

   generate
      if (HOLD_CYC == 0) begin : g_no_hold
         assign extend = 1'b0;
      end else begin : g_hold
         localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (active)
               cnt <= LOAD_VAL;
            else if (cnt != '0)
               cnt <= cnt - 1'b1;
         end

         assign extend = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/ata8_bridge.sv
module ata8_bridge
   import ata8_pkg::*;
#(
   parameter int          ADDR_W   = 10,
   parameter int          WIN_W    = 4,
   parameter int          BYTE_W   = 8,
   parameter logic [9:0]  BASE_LO  = 10'h300,
   parameter logic [9:0]  BASE_HI  = 10'h320,
   parameter int          HOLD_CYC = 4,
   localparam int         REG_W    = WIN_W - 1,
   localparam int         WORD_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_ior_n,
   input  logic              host_iow_n,
   input  logic [BYTE_W-1:0] host_din,
   output logic [BYTE_W-1:0] host_dout,
   output logic              host_doe,
   output logic [REG_W-1:0]  drv_addr,
   output logic              drv_rd_n,
   output logic              drv_wr_n,
   input  logic [WORD_W-1:0] drv_din,
   output logic [WORD_W-1:0] drv_dout,
   output logic              drv_doe
);
   // sampled host cycle
   logic              rd_q, wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         rd_q   <= !host_ior_n;
         wr_q   <= !host_iow_n;
         addr_q <= host_addr;
         din_q  <= host_din;
      end
   end

   logic             hit, odd;
   logic [REG_W-1:0] reg_idx;
   acc_kind_e        kind;

   ata8_window_decode #(
      .ADDR_W (ADDR_W),
      .WIN_W  (WIN_W),
      .BASE_LO(BASE_LO),
      .BASE_HI(BASE_HI)
   ) u_decode (
      .addr    (addr_q),
      .base_sel(base_sel),
      .hit     (hit),
      .reg_idx (reg_idx),
      .odd     (odd),
      .kind    (kind)
   );

   logic              data_reg;
   logic              rd_go, wr_go;
   logic              latch_load;
   logic [BYTE_W-1:0] latch_d, latch_q;
   logic [WORD_W-1:0] wr_word, out_q;
   logic              hold_ext;

   always_comb begin
      data_reg   = (kind == ACC_DATA_LO) || (kind == ACC_DATA_HI);
      // drive read is skipped on the odd data byte, drive write on the even one
      rd_go      = rd_q && (kind != ACC_NONE) && (kind != ACC_DATA_HI);
      wr_go      = wr_q && (kind != ACC_NONE) && (kind != ACC_DATA_LO);
      // holding register loads only on even accesses
      latch_load = hit && !odd && ((rd_q && data_reg) || wr_q);
      latch_d    = rd_q ? drv_din[WORD_W-1:BYTE_W] : din_q;
      wr_word    = data_reg ? {din_q, latch_q} : {{BYTE_W{1'b0}}, din_q};
   end

   ata8_byte_hold #(.BYTE_W(BYTE_W)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (latch_load),
      .d    (latch_d),
      .q    (latch_q)
   );

   // last drive word, kept on the lines through the hold extension
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= '0;
      else if (wr_go)
         out_q <= wr_word;
   end

   ata8_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .active(wr_go),
      .extend(hold_ext)
   );

   assign drv_addr  = reg_idx;
   assign drv_rd_n  = !rd_go;
   assign drv_wr_n  = !wr_go;
   assign drv_dout  = wr_go ? wr_word : out_q;
   assign drv_doe   = wr_go || hold_ext;
   assign host_doe  = hit && rd_q;
   assign host_dout = (kind == ACC_DATA_HI) ? latch_q : drv_din[BYTE_W-1:0];
endmodule

// File: rtl/ata8_bridge_chk.sv
module ata8_bridge_chk #(
   parameter int BYTE_W   = 8,
   parameter int HOLD_CYC = 4,
   localparam int WORD_W  = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hit,
   input logic              odd,
   input logic              data_reg,
   input logic              rd_q,
   input logic              wr_q,
   input logic [BYTE_W-1:0] latch_q,
   input logic              drv_rd_n,
   input logic              drv_wr_n,
   input logic              drv_doe,
   input logic              host_doe,
   input logic [WORD_W-1:0] drv_din,
   input logic [WORD_W-1:0] drv_dout
);
   a_r1_outside_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (drv_rd_n && drv_wr_n && !host_doe));

   a_r3_lo_read_parks_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_rd_n && data_reg && !odd) |=> (latch_q == $past(drv_din[WORD_W-1:BYTE_W])));

   a_r4_hi_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && rd_q && data_reg && odd) |-> drv_rd_n);

   a_r5_lo_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_q && data_reg && !odd) |-> drv_wr_n);

   a_r8_hold_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_doe && drv_wr_n && $past(drv_doe)) |-> $stable(drv_dout));

   generate
      if (HOLD_CYC > 0) begin : g_hold_chk
         a_r8_doe_past_release: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_wr_n) |-> drv_doe);
      end
   endgenerate
endmodule

bind ata8_bridge ata8_bridge_chk #(.BYTE_W(BYTE_W), .HOLD_CYC(HOLD_CYC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hit     (hit),
   .odd     (odd),
   .data_reg(data_reg),
   .rd_q    (rd_q),
   .wr_q    (wr_q),
   .latch_q (latch_q),
   .drv_rd_n(drv_rd_n),
   .drv_wr_n(drv_wr_n),
   .drv_doe (drv_doe),
   .host_doe(host_doe),
   .drv_din (drv_din),
   .drv_dout(drv_dout)
);

// File: tb/ata8_bridge_bench.sv
`timescale 1ns/1ps
module ata8_bridge_bench;
   localparam int HOLD_CYC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_sel = 1'b0;
   logic [9:0]  host_addr = '0;
   logic        host_ior_n = 1'b1;
   logic        host_iow_n = 1'b1;
   logic [7:0]  host_din = '0;
   logic [7:0]  host_dout;
   logic        host_doe;
   logic [2:0]  drv_addr;
   logic        drv_rd_n, drv_wr_n, drv_doe;
   logic [15:0] drv_din, drv_dout;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ata8_bridge #(.HOLD_CYC(HOLD_CYC)) u_ata8_bridge (
      .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .host_addr(host_addr),
      .host_ior_n(host_ior_n), .host_iow_n(host_iow_n), .host_din(host_din),
      .host_dout(host_dout), .host_doe(host_doe), .drv_addr(drv_addr),
      .drv_rd_n(drv_rd_n), .drv_wr_n(drv_wr_n), .drv_din(drv_din),
      .drv_dout(drv_dout), .drv_doe(drv_doe)
   );

   // drive model: sixteen-bit register file
   logic [15:0] dregs [8];
   int rd_pulses = 0;
   int wr_pulses = 0;
   int hold_obs  = 0;

   assign drv_din = dregs[drv_addr];

   always @(posedge drv_wr_n) begin
      if (rst_n) begin
         #1;
         dregs[drv_addr] = drv_dout;
      end
   end
   always @(negedge drv_wr_n) if (rst_n) wr_pulses++;
   always @(negedge drv_rd_n) if (rst_n) rd_pulses++;
   always @(negedge clk) if (rst_n && drv_doe && drv_wr_n) hold_obs++;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_cycle(input bit wr, input logic [9:0] a, input logic [7:0] d,
                             output logic [7:0] q, output logic doe_seen);
      host_addr = a;
      host_din  = d;
      if (wr) host_iow_n = 1'b0; else host_ior_n = 1'b0;
      @(negedge clk);
      q        = host_dout;
      doe_seen = host_doe;
      @(negedge clk);
      host_iow_n = 1'b1;
      host_ior_n = 1'b1;
      repeat (HOLD_CYC + 3) @(negedge clk);
   endtask

   // {write, offset, data, expected read byte}
   localparam int NV = 15;
   localparam logic [20:0] VEC [NV] = '{
      {1'b1, 4'h0, 8'h34, 8'h00},
      {1'b1, 4'h1, 8'h12, 8'h00},
      {1'b0, 4'h0, 8'h00, 8'h34},
      {1'b0, 4'h1, 8'h00, 8'h12},
      {1'b1, 4'h4, 8'h5A, 8'h00},
      {1'b1, 4'h3, 8'hC3, 8'h00},
      {1'b0, 4'h4, 8'h00, 8'h5A},
      {1'b0, 4'h2, 8'h00, 8'hC3},
      {1'b1, 4'h0, 8'hFF, 8'h00},
      {1'b1, 4'h1, 8'h00, 8'h00},
      {1'b0, 4'h1, 8'h00, 8'hFF},
      {1'b0, 4'h0, 8'h00, 8'hFF},
      {1'b0, 4'h1, 8'h00, 8'h00},
      {1'b1, 4'hE, 8'h77, 8'h00},
      {1'b0, 4'hF, 8'h00, 8'h77}
   };

   initial begin
      repeat (500) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] q;
      logic       doe;
      int         p0, p1, h0;

      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 rd strobe", {15'd0, drv_rd_n}, 16'd1);
      chk("R9 wr strobe", {15'd0, drv_wr_n}, 16'd1);
      chk("R9 drive oe",  {15'd0, drv_doe},  16'd0);
      chk("R9 host oe",   {15'd0, host_doe}, 16'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         automatic bit         w    = VEC[i][20];
         automatic logic [3:0] off  = VEC[i][19:16];
         automatic bit         supp = (off[3:1] == 3'd0) && (off[0] == !w);
         p0 = w ? wr_pulses : rd_pulses;
         host_cycle(w, 10'h300 | {6'd0, off}, VEC[i][15:8], q, doe);
         p1 = w ? wr_pulses : rd_pulses;
         // R3 R4 R5 R6 R7: strobe suppressed only on the data-register half that uses the latch
         chk($sformatf("R5/R4 strobe count row %0d", i), 16'(p1 - p0), supp ? 16'd0 : 16'd1);
         // R10 host bus enabled only for reads
         chk($sformatf("R10 host oe row %0d", i), {15'd0, doe}, w ? 16'd0 : 16'd1);
         if (!w)
            chk($sformatf("R3/R4/R2 read byte row %0d", i), {8'd0, q}, {8'd0, VEC[i][7:0]});
      end

      chk("R6 word stored from byte pair", dregs[0], 16'h00FF);
      chk("R7 command write upper zero",   dregs[1], 16'h00C3);
      chk("R2 register 7 at offset 14",    dregs[7], 16'h0077);

      // R8 hold extension after write release
      h0 = hold_obs;
      host_cycle(1'b1, 10'h304, 8'h66, q, doe);
      chk("R8 hold cycles", 16'(hold_obs - h0), 16'(HOLD_CYC));
      chk("R7 even command write", dregs[2], 16'h0066);

      // R1 outside window
      p0 = rd_pulses;
      host_cycle(1'b0, 10'h320, 8'h00, q, doe);
      chk("R1 no host oe outside", {15'd0, doe}, 16'd0);
      chk("R1 no read strobe outside", 16'(rd_pulses - p0), 16'd0);
      p0 = wr_pulses;
      host_cycle(1'b1, 10'h322, 8'hEE, q, doe);
      chk("R1 no write strobe outside", 16'(wr_pulses - p0), 16'd0);
      chk("R1 register untouched", dregs[1], 16'h00C3);

      // R1 alternate base
      base_sel = 1'b1;
      @(negedge clk);
      host_cycle(1'b0, 10'h320, 8'h00, q, doe);
      chk("R1 alt base read", {8'd0, q}, 16'h00FF);
      chk("R1 alt base oe", {15'd0, doe}, 16'd1);
      host_cycle(1'b0, 10'h32E, 8'h00, q, doe);
      chk("R2 alt base reg 7", {8'd0, q}, 16'h0077);
      p0 = rd_pulses;
      host_cycle(1'b0, 10'h300, 8'h00, q, doe);
      chk("R1 old base ignored", 16'(rd_pulses - p0), 16'd0);
      chk("R10 idle host oe", {15'd0, host_doe}, 16'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule